// File: doc/BRIEF.md
# Secure Doorbell Mailbox Register Unit

This unit passes doorbell notifications between an application processor and a system controller through memory-mapped registers. It holds two secure channels. The forward channel carries doorbells from the application processor to the controller. The reverse channel carries them the other way. Each channel has one status register. A set register raises status bits on a write of 1, and a clear register lowers them on a write of 1. Each channel also drives a registered interrupt toward its receiver.

Two independent 32-bit register ports connect to the unit, one for each processor. Either port can reach every register. Bit 31 of each status register is not a doorbell slot. Hardware sets it when a write without the secure qualifier reaches one of that channel's registers, so slots 0 to 30 are the usable doorbells.

Each channel's interrupt comes from a two-state machine:
- `BELL_QUIET`: the status register is zero.
- `BELL_RINGING`: at least one status bit is set.

It has two transitions:
- `ring`: `BELL_QUIET` to `BELL_RINGING`, taken when the next status value is nonzero.
- `hush`: `BELL_RINGING` to `BELL_QUIET`, taken when the next status value is zero.

The interrupt is high exactly in `BELL_RINGING`.

Top module: `mbx_doorbell_unit`

## Requirements
- R1: After reset both status registers read zero and both interrupt outputs are low.
- R2: A write with the secure qualifier high to a set register sets status bit n for each 1 in bits 0..30 of the data. Bits written as 0 are unchanged. The forward channel's set register is at offset 0x308 and its status at 0x300. The reverse channel's set register is at 0x208 and its status at 0x200.
- R3: A secure write to a clear register lowers status bit n for each 1 in the data, including bit 31. Bits written as 0 are unchanged. The clear registers are at 0x310 (forward) and 0x210 (reverse).
- R4: A write that addresses one channel never changes the other channel's status.
- R5: A write with the secure qualifier low to a channel's status, set or clear offset leaves bits 0..30 of that channel unchanged and sets its bit 31.
- R6: A 1 written to bit 31 of a set register is ignored. Bit 31 returns to 0 only through a secure clear write with bit 31 set.
- R7: irq_to_ctrl equals the OR of all forward status bits and irq_to_app equals the OR of all reverse status bits. Both are registered and change in the same cycle as the status they reflect.
- R8: If one port sets a bit and the other port clears the same bit in the same cycle, the bit ends up set.
- R9: Reads of set registers, clear registers and unmapped offsets return zero. A secure write to a status offset changes nothing.
- R10: A status read returns the current value whatever the secure qualifier is, and a read without the secure qualifier sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ap_addr | input | 12 | Application processor port byte offset |
| ap_wr | input | 1 | Application processor port write strobe |
| ap_wdata | input | 32 | Application processor port write data |
| ap_secure | input | 1 | Application processor port secure qualifier |
| ap_rdata | output | 32 | Application processor port read data (combinational) |
| sc_addr | input | 12 | Controller port byte offset |
| sc_wr | input | 1 | Controller port write strobe |
| sc_wdata | input | 32 | Controller port write data |
| sc_secure | input | 1 | Controller port secure qualifier |
| sc_rdata | output | 32 | Controller port read data (combinational) |
| irq_to_ctrl | output | 1 | Forward channel interrupt toward the controller |
| irq_to_app | output | 1 | Reverse channel interrupt toward the application processor |

## Verification
A wrong status bit shows up on the very next status read from either port. In the same cycle it appears as an interrupt that disagrees with that read. A stuck interrupt state machine is caught one cycle after the status becomes zero or nonzero. A misrouted write, a lost set in a set/clear collision, or a missed security flag shows in the read data one cycle after the write. The bench compares both read ports and both interrupts against its model in every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int NUM_CH   = 2;
    localparam int NUM_PORT = 2;
    localparam int FLAG_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] STAT_OFF = 12'h000;
    localparam logic [ADDR_W-1:0] SET_OFF  = 12'h008;
    localparam logic [ADDR_W-1:0] CLR_OFF  = 12'h010;

    localparam logic [DATA_W-1:0] FLAG_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    typedef enum logic {
        BELL_QUIET,
        BELL_RINGING
    } bell_state_e;

    // One port's write request toward one channel
    typedef struct packed {
        logic [DATA_W-1:0] set_m;
        logic [DATA_W-1:0] clr_m;
        logic              nsec;
    } ch_req_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FWD_BASE = 12'h300,
    parameter logic [ADDR_W-1:0] REV_BASE = 12'h200
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          secure,
    input  logic [NUM_CH-1:0][DATA_W-1:0] status,
    output ch_req_t [NUM_CH-1:0]          req,
    output logic [DATA_W-1:0]             rdata
);
    logic [NUM_CH-1:0] stat_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = (c == 0) ? FWD_BASE : REV_BASE;
        logic set_hit, clr_hit;

        assign stat_hit[c] = (addr == BASE + STAT_OFF);
        assign set_hit     = (addr == BASE + SET_OFF);
        assign clr_hit     = (addr == BASE + CLR_OFF);

        assign req[c].set_m = (wr && secure && set_hit) ? wdata : '0;
        assign req[c].clr_m = (wr && secure && clr_hit) ? wdata : '0;
        assign req[c].nsec  = wr && !secure && (stat_hit[c] || set_hit || clr_hit);
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (stat_hit[c]) rdata = status[c];
        end
    end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  ch_req_t [NUM_PORT-1:0]  req,
    output logic [DATA_W-1:0]       status,
    output logic                    irq
);
    logic [DATA_W-1:0] set_acc, clr_acc, status_nx;
    logic              nsec_acc;
    bell_state_e       state, state_nx;

    // Merge all ports. Sets are applied after clears, so a set wins a collision.
    always_comb begin
        set_acc  = '0;
        clr_acc  = '0;
        nsec_acc = 1'b0;
        for (int p = 0; p < NUM_PORT; p++) begin
            set_acc  = set_acc | req[p].set_m;
            clr_acc  = clr_acc | req[p].clr_m;
            nsec_acc = nsec_acc | req[p].nsec;
        end
        status_nx = (status & ~clr_acc) | (set_acc & ~FLAG_MASK)
                  | (nsec_acc ? FLAG_MASK : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= status_nx;
    end

    // Interrupt state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BELL_QUIET;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            BELL_QUIET:   if (|status_nx)  state_nx = BELL_RINGING; // ring
            BELL_RINGING: if (!(|status_nx)) state_nx = BELL_QUIET; // hush
            default:      state_nx = BELL_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            BELL_RINGING: irq = 1'b1;
            default:      irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbx_doorbell_unit.sv
module mbx_doorbell_unit
    import mbx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FWD_BASE = 12'h300,
    parameter logic [ADDR_W-1:0] REV_BASE = 12'h200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ap_addr,
    input  logic              ap_wr,
    input  logic [DATA_W-1:0] ap_wdata,
    input  logic              ap_secure,
    output logic [DATA_W-1:0] ap_rdata,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              sc_wr,
    input  logic [DATA_W-1:0] sc_wdata,
    input  logic              sc_secure,
    output logic [DATA_W-1:0] sc_rdata,
    output logic              irq_to_ctrl,
    output logic              irq_to_app
);
    logic [NUM_PORT-1:0][ADDR_W-1:0]  p_addr;
    logic [NUM_PORT-1:0]              p_wr, p_sec;
    logic [NUM_PORT-1:0][DATA_W-1:0]  p_wdata, p_rdata;
    ch_req_t [NUM_PORT-1:0][NUM_CH-1:0] dec_req;
    ch_req_t [NUM_CH-1:0][NUM_PORT-1:0] chan_in;
    logic [NUM_CH-1:0][DATA_W-1:0]    ch_status;
    logic [NUM_CH-1:0]                ch_irq;
    logic [DATA_W-1:0]                fwd_status, rev_status;

    assign p_addr[0]  = ap_addr;
    assign p_wr[0]    = ap_wr;
    assign p_wdata[0] = ap_wdata;
    assign p_sec[0]   = ap_secure;
    assign p_addr[1]  = sc_addr;
    assign p_wr[1]    = sc_wr;
    assign p_wdata[1] = sc_wdata;
    assign p_sec[1]   = sc_secure;
    assign ap_rdata   = p_rdata[0];
    assign sc_rdata   = p_rdata[1];

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        mbx_port_decode #(.FWD_BASE(FWD_BASE), .REV_BASE(REV_BASE)) u_dec (
            .addr   (p_addr[p]),
            .wr     (p_wr[p]),
            .wdata  (p_wdata[p]),
            .secure (p_sec[p]),
            .status (ch_status),
            .req    (dec_req[p]),
            .rdata  (p_rdata[p])
        );
        for (genvar c = 0; c < NUM_CH; c++) begin : g_route
            assign chan_in[c][p] = dec_req[p][c];
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        mbx_channel u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (chan_in[c]),
            .status (ch_status[c]),
            .irq    (ch_irq[c])
        );
    end

    assign fwd_status  = ch_status[0];
    assign rev_status  = ch_status[1];
    assign irq_to_ctrl = ch_irq[0];
    assign irq_to_app  = ch_irq[1];
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
    import mbx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FWD_BASE = 12'h300,
    parameter logic [ADDR_W-1:0] REV_BASE = 12'h200
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ap_addr,
    input logic              ap_wr,
    input logic [DATA_W-1:0] ap_wdata,
    input logic              ap_secure,
    input logic [DATA_W-1:0] ap_rdata,
    input logic [ADDR_W-1:0] sc_addr,
    input logic              sc_wr,
    input logic              sc_secure,
    input logic [DATA_W-1:0] sc_wdata,
    input logic [DATA_W-1:0] fwd_status,
    input logic [DATA_W-1:0] rev_status,
    input logic              irq_to_ctrl,
    input logic              irq_to_app
);
    logic ap_fwd_reg, sc_fwd_reg, fwd_ns_wr, rev_clr0;

    assign ap_fwd_reg = (ap_addr == FWD_BASE) || (ap_addr == FWD_BASE + SET_OFF)
                     || (ap_addr == FWD_BASE + CLR_OFF);
    assign sc_fwd_reg = (sc_addr == FWD_BASE) || (sc_addr == FWD_BASE + SET_OFF)
                     || (sc_addr == FWD_BASE + CLR_OFF);
    assign fwd_ns_wr  = (ap_wr && !ap_secure && ap_fwd_reg)
                     || (sc_wr && !sc_secure && sc_fwd_reg);
    assign rev_clr0   = (ap_wr && ap_secure && ap_addr == REV_BASE + CLR_OFF && ap_wdata[0])
                     || (sc_wr && sc_secure && sc_addr == REV_BASE + CLR_OFF && sc_wdata[0]);

    // R5
    nsec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_wr && !ap_secure && ap_fwd_reg) |=> fwd_status[FLAG_BIT]);

    // R5
    nsec_keeps_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_wr && !ap_secure && ap_fwd_reg && !sc_wr)
        |=> fwd_status[FLAG_BIT-1:0] == $past(fwd_status[FLAG_BIT-1:0]));

    // R6
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd_status[FLAG_BIT]) |-> $past(fwd_ns_wr));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_wr && ap_secure && ap_addr == FWD_BASE + SET_OFF && ap_wdata[0])
        |=> fwd_status[0]);

    // R3
    clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rev_status[0]) |-> $past(rev_clr0));

    // R7
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_to_ctrl == (|fwd_status)) && (irq_to_app == (|rev_status)));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_addr != FWD_BASE && ap_addr != REV_BASE) |-> ap_rdata == '0);
endmodule

bind mbx_doorbell_unit mbx_doorbell_chk #(.FWD_BASE(FWD_BASE), .REV_BASE(REV_BASE)) u_chk (.*);

// File: tb/sim_mbx_doorbell_unit.sv
`timescale 1ns/1ps
module sim_mbx_doorbell_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ap_addr = '0, sc_addr = '0;
    logic        ap_wr = 1'b0, sc_wr = 1'b0, ap_secure = 1'b0, sc_secure = 1'b0;
    logic [31:0] ap_wdata = '0, sc_wdata = '0;
    logic [31:0] ap_rdata, sc_rdata;
    logic        irq_to_ctrl, irq_to_app;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural model: index 0 forward (0x300), index 1 reverse (0x200)
    logic [31:0] m_st [2];

    always #2.5 clk = ~clk;

    mbx_doorbell_unit u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [11:0] a);
        if (a == 12'h300) return m_st[0];
        if (a == 12'h200) return m_st[1];
        return 32'h0;
    endfunction

    function automatic int m_chan(logic [11:0] a);
        if (a == 12'h300 || a == 12'h308 || a == 12'h310) return 0;
        if (a == 12'h200 || a == 12'h208 || a == 12'h210) return 1;
        return -1;
    endfunction

    // One cycle: drive both ports, check reads and irqs, advance the model
    task automatic step(string tag,
                        logic [11:0] aa, logic aw, logic [31:0] ad, logic as_,
                        logic [11:0] ba, logic bw, logic [31:0] bd, logic bs);
        logic [11:0] pa [2];
        logic        pw [2];
        logic [31:0] pd [2];
        logic        ps [2];
        logic [31:0] setm [2];
        logic [31:0] clrm [2];
        bit          flag [2];
        @(negedge clk);
        ap_addr = aa; ap_wr = aw; ap_wdata = ad; ap_secure = as_;
        sc_addr = ba; sc_wr = bw; sc_wdata = bd; sc_secure = bs;
        #1;
        chk({tag, " ap read"}, ap_rdata, m_read(aa));
        chk({tag, " sc read"}, sc_rdata, m_read(ba));
        chk("R7 irq_to_ctrl", {31'b0, irq_to_ctrl}, {31'b0, |m_st[0]});
        chk("R7 irq_to_app", {31'b0, irq_to_app}, {31'b0, |m_st[1]});
        pa[0] = aa; pw[0] = aw; pd[0] = ad; ps[0] = as_;
        pa[1] = ba; pw[1] = bw; pd[1] = bd; ps[1] = bs;
        for (int c = 0; c < 2; c++) begin
            setm[c] = 0; clrm[c] = 0; flag[c] = 0;
        end
        for (int p = 0; p < 2; p++) begin
            int c = m_chan(pa[p]);
            if (pw[p] && c >= 0) begin
                if (!ps[p]) flag[c] = 1;
                else if (pa[p][4]) clrm[c] |= pd[p];
                else if (pa[p][3]) setm[c] |= pd[p];
            end
        end
        for (int c = 0; c < 2; c++) begin
            m_st[c] = m_st[c] & ~clrm[c];
            m_st[c] = m_st[c] | (setm[c] & 32'h7fff_ffff);
            if (flag[c]) m_st[c][31] = 1'b1;
        end
    endtask

    task automatic idle(string tag, logic [11:0] aa, logic [11:0] ba);
        step(tag, aa, 1'b0, 32'h0, 1'b1, ba, 1'b0, 32'h0, 1'b1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_st[0] = 0; m_st[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        idle("R1", 12'h300, 12'h200);
        // R2 set forward slots from the application port
        step("R2", 12'h308, 1, 32'h0000_0005, 1, 12'h300, 0, 0, 1);
        step("R2", 12'h308, 1, 32'h0000_0100, 1, 12'h300, 0, 0, 1);
        idle("R2", 12'h300, 12'h300);
        // R4 reverse channel untouched by forward writes
        idle("R4", 12'h200, 12'h200);
        step("R4", 12'h300, 0, 0, 1, 12'h208, 1, 32'h4000_0002, 1);
        idle("R4", 12'h300, 12'h200);
        // R3 clear some bits, zero bits unchanged
        step("R3", 12'h310, 1, 32'h0000_0001, 1, 12'h300, 0, 0, 1);
        idle("R3", 12'h300, 12'h300);
        step("R3", 12'h210, 1, 32'hffff_ffff, 1, 12'h200, 0, 0, 1);
        idle("R3", 12'h200, 12'h200);
        // R6 bit 31 through set register ignored
        step("R6", 12'h208, 1, 32'h8000_0000, 1, 12'h200, 0, 0, 1);
        idle("R6", 12'h200, 12'h200);
        // R5 non-secure writes flag bit 31 and leave slots
        step("R5", 12'h310, 1, 32'hffff_ffff, 0, 12'h300, 0, 0, 1);
        idle("R5", 12'h300, 12'h300);
        step("R5", 12'h200, 0, 0, 1, 12'h208, 1, 32'h0000_00ff, 0);
        idle("R5", 12'h200, 12'h200);
        // R6 secure clear of bit 31
        step("R6", 12'h310, 1, 32'h8000_0000, 1, 12'h210, 1, 32'h8000_0000, 1);
        idle("R6", 12'h300, 12'h200);
        // R8 set and clear of the same bit in one cycle
        step("R8", 12'h308, 1, 32'h0000_0010, 1, 12'h310, 1, 32'h0000_0010, 1);
        idle("R8", 12'h300, 12'h300);
        step("R8", 12'h210, 1, 32'h0000_0003, 1, 12'h208, 1, 32'h0000_0003, 1);
        idle("R8", 12'h200, 12'h200);
        // R9 reads of set, clear, unmapped; secure write to status ignored
        idle("R9", 12'h308, 12'h210);
        idle("R9", 12'h30c, 12'h000);
        step("R9", 12'h300, 1, 32'h0000_0f00, 1, 12'h200, 1, 32'h0, 1);
        idle("R9", 12'h300, 12'h200);
        // R10 non-secure reads return status, set no flag
        step("R10", 12'h300, 0, 0, 0, 12'h200, 0, 0, 0);
        idle("R10", 12'h300, 12'h200);
        // R7 drain both channels so interrupts drop
        step("R7", 12'h310, 1, 32'hffff_ffff, 1, 12'h210, 1, 32'hffff_ffff, 1);
        idle("R7", 12'h300, 12'h200);
        // Random traffic on both ports
        for (int i = 0; i < 600; i++) begin
            logic [11:0] pool [8];
            pool = '{12'h200, 12'h208, 12'h210, 12'h300, 12'h308, 12'h310, 12'h30c, 12'h000};
            step("R2", pool[$urandom_range(7)], 1'($urandom_range(1)), $urandom & $urandom,
                 1'($urandom_range(3) != 0),
                 pool[$urandom_range(7)], 1'($urandom_range(1)), $urandom & $urandom,
                 1'($urandom_range(3) != 0));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule